// File: doc/BRIEF.md
# Conversion Status Flag Controller

This block keeps the status and interrupt flags of one digital filter. Two conversion groups are tracked: a regular group and a higher-priority injected group. For each group it keeps three flags. The end-of-conversion flag says a result is waiting. The overrun flag says a result arrived while the previous one was still unread. The busy flag covers both the pending and the converting phase of a requested conversion. The block also keeps a watchdog summary flag, a clock-absence bit for each channel and a short-circuit bit for each channel.

The filter datapath drives the block with single-cycle completion pulses and data-read strobes. The trigger logic drives it with start requests. The channel logic supplies enable and synchronisation levels, clock-loss and short-circuit event pulses, and the raw high/low watchdog source flags. Software clears flags by writing ones through a clear strobe with a mask. The block returns a read-only status word and one interrupt line. A per-group load strobe tells the datapath whether a finishing conversion may overwrite the data register; an overrun keeps the old contents.

Top module: `conv_status_flags`

## Requirements
- R1: The end-of-conversion flag of a group (status bit 0 regular, bit 1 injected) is 1 the cycle after a completion pulse of that group, and goes to 0 the cycle after a data-read strobe of that group that has no completion pulse in the same cycle. A clear-register write never changes it.
- R2: A completion pulse that arrives while the group's end-of-conversion flag is 1 sets that group's overrun flag (bit 2 regular, bit 3 injected) on the next cycle. During such a pulse the group's load strobe is 0. During a completion pulse with the flag at 0, the load strobe is 1.
- R3: An overrun flag is not changed by data reads. It goes to 0 only after a clear-register write with mask bit 2 (regular) or bit 3 (injected) set.
- R4: A group's busy flag (bit 5 regular, bit 6 injected) rises the cycle after a start request while it is 0 and drops the cycle after that group's completion pulse. A start request while it is 1 has no effect.
- R5: The watchdog flag (bit 4) is the registered OR of 8 high-threshold and 8 low-threshold source flags. It stays 1 until every source flag is 0.
- R6: Clock-absence bit c (status bit 8+c) is set by a clock-loss pulse on channel c. It is held at 1 while channel c is disabled or not synchronised, and otherwise cleared by a clear write with mask bit 8+c.
- R7: Short-circuit bit c (status bit 16+c) is set by a detector pulse on an enabled channel c. It is cleared by a clear write with mask bit 16+c, or on the cycle after channel c is disabled.
- R8: When a set event and a clear write hit the same flag in the same cycle, the flag ends up at 1.
- R9: irq is 1 in the same cycle exactly when some status bit and the same bit of irq_en are both 1.
- R10: Clear-register mask bits that are 0 have no effect, a mask with clr_wr at 0 has no effect, and status bit 7 always reads 0.
- R11: After reset, every flag is 0 except the clock-absence bits, which are all 1 (status = 0x00FF00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_start | input | 1 | Regular group start request (software or trigger) |
| inj_start | input | 1 | Injected group start request |
| reg_done | input | 1 | Regular conversion completion pulse |
| inj_done | input | 1 | Injected conversion completion pulse |
| reg_data_rd | input | 1 | Regular data register read strobe |
| inj_data_rd | input | 1 | Injected data register read strobe |
| clr_wr | input | 1 | Clear register write strobe |
| clr_mask | input | 24 | Write-1-to-clear mask, same bit positions as status |
| ch_en | input | 8 | Per-channel enable |
| ch_synced | input | 8 | Per-channel transceiver synchronised |
| clk_loss_evt | input | 8 | Per-channel clock loss detected pulse |
| short_evt | input | 8 | Per-channel short-circuit counter limit pulse |
| wd_hi_src | input | 8 | Watchdog high-threshold source flags |
| wd_lo_src | input | 8 | Watchdog low-threshold source flags |
| irq_en | input | 24 | Interrupt enable per status bit |
| status | output | 24 | Packed status word |
| irq | output | 1 | Interrupt request |
| reg_load | output | 1 | Regular data register may be written this cycle |
| inj_load | output | 1 | Injected data register may be written this cycle |

## Verification
The group flags are driven with completion pulses on an empty slot and on a full slot, which separates a plain result from an overrun. Reads and clears are mixed with completions in the same cycle, which shows whether set-over-clear priority holds and whether an end flag can be cleared the wrong way. Start requests are sent to idle and to busy groups, so an ignored request can be told apart from a restarted one. The channel flags are exercised with events, disables and unsynchronised states, one channel at a time, so each forcing or clearing source can be seen on its own bit.

// File: rtl/csf_pkg.sv
package csf_pkg;

  // status word layout shared by every module of the block
  localparam int GROUPS    = 2;  // 0 regular, 1 injected
  localparam int EOC_LSB   = 0;
  localparam int OVR_LSB   = 2;
  localparam int AWD_BIT   = 4;
  localparam int BUSY_LSB  = 5;
  localparam int RSVD_BIT  = 7;
  localparam int CKAB_LSB  = 8;

  typedef struct packed {
    logic busy;
    logic ovr;
    logic eoc;
  } grp_flags_t;

  // end flag: a completion sets it, a read clears it, set has priority
  function automatic logic eoc_next(logic q, logic done, logic rd);
    return done | (q & ~rd);
  endfunction

  // overrun: completion on an occupied slot, sticky until write-1 clear
  function automatic logic ovr_next(logic q, logic done, logic eoc_q, logic clr);
    return (done & eoc_q) | (q & ~clr);
  endfunction

  // busy: accepted only when idle, ends on completion
  function automatic logic busy_next(logic q, logic start, logic done);
    return q ? ~done : start;
  endfunction

  // generic sticky flag with write-1 clear, set wins
  function automatic logic sticky_w1c(logic q, logic set, logic clr);
    return set | (q & ~clr);
  endfunction

endpackage

// File: rtl/csf_group_track.sv
module csf_group_track
  import csf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       done,
  input  logic       data_rd,
  input  logic       ovr_clr,
  output grp_flags_t flags,
  output logic       load
);

  grp_flags_t flags_q;

  // named internal events for the assertions
  logic ovr_evt;
  logic start_ok;

  assign ovr_evt  = done & flags_q.eoc;
  assign start_ok = start & ~flags_q.busy;
  assign load     = done & ~flags_q.eoc;
  assign flags    = flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q.eoc  <= eoc_next(flags_q.eoc, done, data_rd);
      flags_q.ovr  <= ovr_next(flags_q.ovr, done, flags_q.eoc, ovr_clr);
      flags_q.busy <= busy_next(flags_q.busy, start, done);
    end
  end

  a_r1_eoc_set: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flags.eoc);

  a_r1_eoc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !done) |=> !flags.eoc);

  a_r2_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> flags.ovr);

  a_r2_no_load_on_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flags.eoc) |-> !load);

  a_r3_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.ovr && !ovr_clr) |=> flags.ovr);

  a_r4_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> flags.busy);

  a_r4_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.busy && !done) |=> flags.busy);

  a_r4_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.busy && done) |=> !flags.busy);

  a_r8_ovr_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && done && flags.eoc) |=> flags.ovr);

endmodule

// File: rtl/csf_chan_flags.sv
module csf_chan_flags
  import csf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic synced,
  input  logic loss_evt,
  input  logic scd_evt,
  input  logic clr_ckab,
  input  logic clr_scd,
  output logic ckab,
  output logic scd
);

  logic ckab_q;
  logic scd_q;
  logic ckab_force;
  logic scd_set;

  assign ckab_force = ~en | ~synced;
  assign scd_set    = en & scd_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ckab_q <= 1'b1;
      scd_q  <= 1'b0;
    end else begin
      ckab_q <= ckab_force | sticky_w1c(ckab_q, loss_evt, clr_ckab);
      scd_q  <= en & sticky_w1c(scd_q, scd_evt, clr_scd);
    end
  end

  assign ckab = ckab_q;
  assign scd  = scd_q;

  a_r6_ckab_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || !synced) |=> ckab);

  a_r6_ckab_loss: assert property (@(posedge clk) disable iff (!rst_n)
    loss_evt |=> ckab);

  a_r6_ckab_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ckab && !clr_ckab) |=> ckab);

  a_r7_scd_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scd);

  a_r7_scd_set: assert property (@(posedge clk) disable iff (!rst_n)
    scd_set |=> scd);

  a_r8_ckab_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (loss_evt && clr_ckab) |=> ckab);

endmodule

// File: rtl/csf_awd_summary.sv
module csf_awd_summary #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hi_src,
  input  logic [NUM_SRC-1:0] lo_src,
  output logic               awd
);

  logic any_src;
  logic awd_q;

  assign any_src = (|hi_src) | (|lo_src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) awd_q <= 1'b0;
    else        awd_q <= any_src;
  end

  assign awd = awd_q;

  a_r5_awd_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_src != '0) || (lo_src != '0)) |=> awd);

  a_r5_awd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_src == '0) && (lo_src == '0)) |=> !awd);

endmodule

// File: rtl/conv_status_flags.sv
module conv_status_flags
  import csf_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int SCD_LSB = CKAB_LSB + NUM_CH,
  localparam int STAT_W  = CKAB_LSB + 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_start,
  input  logic              inj_start,
  input  logic              reg_done,
  input  logic              inj_done,
  input  logic              reg_data_rd,
  input  logic              inj_data_rd,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_synced,
  input  logic [NUM_CH-1:0] clk_loss_evt,
  input  logic [NUM_CH-1:0] short_evt,
  input  logic [NUM_CH-1:0] wd_hi_src,
  input  logic [NUM_CH-1:0] wd_lo_src,
  input  logic [STAT_W-1:0] irq_en,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              reg_load,
  output logic              inj_load
);

  // mask bits that address no clearable flag
  localparam logic [STAT_W-1:0] NOCLR_MASK =
    ~(({STAT_W{1'b0}} | (STAT_W'(2'b11) << OVR_LSB))
      | ({STAT_W{1'b1}} << CKAB_LSB));

  logic [GROUPS-1:0] grp_start, grp_done, grp_rd, grp_load, grp_ovr_clr;
  grp_flags_t        grp_flags [GROUPS];
  logic [STAT_W-1:0] clr_eff;
  logic [NUM_CH-1:0] ckab_v, scd_v;
  logic              awd;

  assign grp_start = {inj_start, reg_start};
  assign grp_done  = {inj_done, reg_done};
  assign grp_rd    = {inj_data_rd, reg_data_rd};
  assign clr_eff   = clr_wr ? (clr_mask & ~NOCLR_MASK) : '0;

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign grp_ovr_clr[g] = clr_eff[OVR_LSB + g];
      csf_group_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (grp_start[g]),
        .done    (grp_done[g]),
        .data_rd (grp_rd[g]),
        .ovr_clr (grp_ovr_clr[g]),
        .flags   (grp_flags[g]),
        .load    (grp_load[g])
      );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      csf_chan_flags u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ch_en[c]),
        .synced   (ch_synced[c]),
        .loss_evt (clk_loss_evt[c]),
        .scd_evt  (short_evt[c]),
        .clr_ckab (clr_eff[CKAB_LSB + c]),
        .clr_scd  (clr_eff[SCD_LSB + c]),
        .ckab     (ckab_v[c]),
        .scd      (scd_v[c])
      );
    end
  endgenerate

  csf_awd_summary #(.NUM_SRC(NUM_CH)) u_awd (
    .clk    (clk),
    .rst_n  (rst_n),
    .hi_src (wd_hi_src),
    .lo_src (wd_lo_src),
    .awd    (awd)
  );

  always_comb begin
    status = '0;
    for (int g = 0; g < GROUPS; g++) begin
      status[EOC_LSB + g]  = grp_flags[g].eoc;
      status[OVR_LSB + g]  = grp_flags[g].ovr;
      status[BUSY_LSB + g] = grp_flags[g].busy;
    end
    status[AWD_BIT]             = awd;
    status[CKAB_LSB +: NUM_CH]  = ckab_v;
    status[SCD_LSB +: NUM_CH]   = scd_v;
  end

  assign irq      = |(status & irq_en);
  assign reg_load = grp_load[0];
  assign inj_load = grp_load[1];

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & irq_en) == '0) |-> !irq);

  a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !status[RSVD_BIT]);

  a_r10_eoc_not_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && ((clr_mask & NOCLR_MASK) != '0) && status[EOC_LSB] && !reg_data_rd)
    |=> status[EOC_LSB]);

  a_r1_load_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    reg_load |-> reg_done);

endmodule

// File: tb/conv_status_flags_bench.sv
`timescale 1ns/1ps
module conv_status_flags_bench;

  localparam int W = 24;

  logic clk = 0;
  logic rst_n = 0;
  logic reg_start = 0, inj_start = 0, reg_done = 0, inj_done = 0;
  logic reg_data_rd = 0, inj_data_rd = 0, clr_wr = 0;
  logic [W-1:0] clr_mask = '0, irq_en = '0;
  logic [7:0] ch_en = 8'hFF, ch_synced = 8'hFF;
  logic [7:0] clk_loss_evt = '0, short_evt = '0, wd_hi_src = '0, wd_lo_src = '0;
  logic [W-1:0] status;
  logic irq, reg_load, inj_load;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  conv_status_flags u_conv_status_flags (
    .clk(clk), .rst_n(rst_n),
    .reg_start(reg_start), .inj_start(inj_start),
    .reg_done(reg_done), .inj_done(inj_done),
    .reg_data_rd(reg_data_rd), .inj_data_rd(inj_data_rd),
    .clr_wr(clr_wr), .clr_mask(clr_mask),
    .ch_en(ch_en), .ch_synced(ch_synced),
    .clk_loss_evt(clk_loss_evt), .short_evt(short_evt),
    .wd_hi_src(wd_hi_src), .wd_lo_src(wd_lo_src),
    .irq_en(irq_en), .status(status), .irq(irq),
    .reg_load(reg_load), .inj_load(inj_load)
  );

  // {reg_done, inj_done, reg_rd, inj_rd, reg_start, inj_start, clr_wr}, mask, expected status
  localparam int NV = 15;
  localparam logic [54:0] VECS [NV] = '{
    {7'b0000001, 24'h00FF00, 24'h000000},  // R6 clear all clock-absence bits
    {7'b1000000, 24'h000000, 24'h000001},  // R1 regular result
    {7'b1000000, 24'h000000, 24'h000005},  // R2 regular overrun
    {7'b0010000, 24'h000000, 24'h000004},  // R1 read clears end, R3 overrun stays
    {7'b0000001, 24'h000004, 24'h000000},  // R3 clear regular overrun
    {7'b0000100, 24'h000000, 24'h000020},  // R4 regular start
    {7'b0000010, 24'h000000, 24'h000060},  // R4 injected start
    {7'b0100100, 24'h000000, 24'h000022},  // R4 start ignored while busy, injected done
    {7'b1000001, 24'h000004, 24'h000003},  // R4 regular done, clear with nothing set
    {7'b0101000, 24'h000000, 24'h00000B},  // R8 done and read together, injected overrun
    {7'b0000001, 24'hFFFFF7, 24'h00000B},  // R10 zero mask bit and end flags untouched
    {7'b0100001, 24'h000008, 24'h00000B},  // R8 overrun set wins over clear
    {7'b0011000, 24'h000000, 24'h000008},  // R3 reads leave overrun
    {7'b0000000, 24'h000008, 24'h000008},  // R10 mask without write strobe
    {7'b0000001, 24'h000008, 24'h000000}   // R3 injected overrun cleared
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%06h expected 0x%06h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clr_pulses();
    reg_done = 0; inj_done = 0; reg_data_rd = 0; inj_data_rd = 0;
    reg_start = 0; inj_start = 0; clr_wr = 0; clr_mask = '0;
    clk_loss_evt = '0; short_evt = '0;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R11 reset status", status, 24'h00FF00);
    chk("R9 irq low after reset", {23'd0, irq}, 24'd0);

    for (int i = 0; i < NV; i++) begin
      {reg_done, inj_done, reg_data_rd, inj_data_rd, reg_start, inj_start, clr_wr} = VECS[i][54:48];
      clr_mask = VECS[i][47:24];
      tick();
      chk($sformatf("vector %0d", i), status, VECS[i][23:0]);
    end
    clr_pulses();

    // R2 load strobes
    reg_done = 1; #1;
    chk("R2 load on empty slot", {23'd0, reg_load}, 24'd1);
    tick(); reg_done = 0;
    chk("R1 regular end flag", status, 24'h000001);
    reg_done = 1; #1;
    chk("R2 no load on overrun", {23'd0, reg_load}, 24'd0);
    tick(); reg_done = 0;
    reg_data_rd = 1; clr_wr = 1; clr_mask = 24'h000004;
    tick(); clr_pulses();
    chk("R3 regular cleared", status, 24'h000000);
    inj_done = 1; #1;
    chk("R2 injected load", {23'd0, inj_load}, 24'd1);
    tick(); inj_done = 0; inj_data_rd = 1;
    tick(); inj_data_rd = 0;

    // R5 watchdog summary and R9 interrupt
    wd_hi_src = 8'h08; tick();
    chk("R5 watchdog set by high source", status, 24'h000010);
    irq_en = 24'h000010; #1;
    chk("R9 irq enabled flag", {23'd0, irq}, 24'd1);
    irq_en = 24'h000008; #1;
    chk("R9 irq other enable", {23'd0, irq}, 24'd0);
    irq_en = '0;
    wd_lo_src = 8'h01; wd_hi_src = 8'h00; tick();
    chk("R5 watchdog held by low source", status, 24'h000010);
    wd_lo_src = 8'h00; tick();
    chk("R5 watchdog clears when all sources clear", status, 24'h000000);

    // R6 clock absence
    clk_loss_evt = 8'h04; tick(); clk_loss_evt = '0;
    chk("R6 clock loss sets bit", status, 24'h000400);
    clk_loss_evt = 8'h04; clr_wr = 1; clr_mask = 24'h000400; tick(); clr_pulses();
    chk("R8 clock loss wins over clear", status, 24'h000400);
    clr_wr = 1; clr_mask = 24'h000400; tick(); clr_pulses();
    chk("R6 clock absence cleared", status, 24'h000000);
    ch_en = 8'hDF; tick();
    chk("R6 forced while disabled", status, 24'h002000);
    clr_wr = 1; clr_mask = 24'h002000; tick();
    chk("R6 clear ignored while disabled", status, 24'h002000);
    ch_en = 8'hFF; tick(); clr_pulses();
    chk("R6 clear after enable", status, 24'h000000);
    ch_synced = 8'hBF; tick(); ch_synced = 8'hFF;
    chk("R6 forced while unsynced", status, 24'h004000);
    tick();
    chk("R6 held after sync until cleared", status, 24'h004000);
    clr_wr = 1; clr_mask = 24'h004000; tick(); clr_pulses();
    chk("R6 cleared after sync", status, 24'h000000);

    // R7 short circuit
    short_evt = 8'h02; tick(); short_evt = '0;
    chk("R7 short event sets bit", status, 24'h020000);
    clr_wr = 1; clr_mask = 24'h020000; tick(); clr_pulses();
    chk("R7 short bit cleared", status, 24'h000000);
    short_evt = 8'h10; tick(); short_evt = '0;
    chk("R7 short on channel 4", status, 24'h100000);
    ch_en = 8'hEF; tick();
    chk("R7 disable clears short bit", status, 24'h001000);
    short_evt = 8'h10; tick(); short_evt = '0;
    chk("R7 event ignored while disabled", status, 24'h001000);
    ch_en = 8'hFF; clr_wr = 1; clr_mask = 24'h001000; tick(); clr_pulses();
    chk("R10 status bit 7 and idle state", status, 24'h000000);

    // R11 reset in the middle of activity
    reg_done = 1; short_evt = 8'h01; tick(); clr_pulses();
    rst_n = 0; #1;
    chk("R11 asynchronous reset", status, 24'h00FF00);
    tick(); rst_n = 1; #1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule